// File: doc/BRIEF.md
# Serial-Programmed Clock Fan-Out Enable Controller

This block takes one reference clock and fans it out to eighteen gated copies. Each copy has its own enable bit. The enable bits sit in three 8-bit registers that an external master fills over a two-wire serial bus (I2C, standard mode). The block answers only as a slave receiver at a fixed 7-bit address, and it accepts write traffic only. A fast system clock oversamples both bus lines. The samples are synchronized and filtered, and a small state machine decodes START, STOP, the address, data bits and acknowledge slots.

A programming transaction has a fixed byte order. The address byte comes first. A command byte and a byte-count byte follow, and the block acknowledges both but does not use their values. After them come up to three data bytes, which land in register 0, register 1 and register 2, always in that order. A transaction may end after any data byte, and only the registers actually received are changed. A disabled output is driven low. A global output-enable input decides whether the output pads drive at all.

FSM states:
- `ST_IDLE`: waits for START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ACK`: pulls the data line low for one bit slot.
- `ST_DATA`: shifts in a payload byte.
- `ST_IGNORE`: the address did not match, so the block stays silent until the next START.

Transitions:
- A START from any state goes to `ST_ADDR`.
- A STOP from any state goes to `ST_IDLE`.
- From `ST_ADDR`, on the clock fall after eight bits, a matching write address goes to `ST_ACK`; any other address goes to `ST_IGNORE`.
- From `ST_DATA`, on the clock fall after eight bits, the block goes to `ST_ACK`.
- From `ST_ACK`, on the next clock fall, the block goes to `ST_DATA`.

Top module: `i2cen_top`

## Requirements
- R1: After reset all 18 enable bits are 1, so with `out_en_i` high every `clk_o` bit equals `ref_clk_i`.
- R2: An address byte equal to 1101001 in bits 7..1 with bit 0 (the R/W flag) equal to 0 is acknowledged: `sda_oe_o` pulls the data line low during the ninth clock pulse. Every later byte of that transaction is acknowledged in the same way. Bits arrive MSB first.
- R3: Any other address, or the same address with bit 0 equal to 1, is not acknowledged. No later byte before the next START is acknowledged, and no register changes.
- R4: After the address, the first two bytes are ignored. The third, fourth and fifth bytes are written to register 0, register 1 and register 2.
- R5: A STOP after the third or fourth byte updates only the registers whose bytes were fully received.
- R6: Every new transaction starts over at the command byte, so its first data byte always goes to register 0.
- R7: `clk_o[7:0]` is enabled by register 0 bits 7..0 and `clk_o[15:8]` by register 1 bits 7..0. `clk_o[16]` is enabled by register 2 bit 6 and `clk_o[17]` by register 2 bit 7. Register 2 bits 5..0 accept writes and have no effect.
- R8: An output whose enable bit is 0 is low whatever `ref_clk_i` does. An output whose enable bit is 1 equals `ref_clk_i`.
- R9: `pad_drive_o` is 0 while `out_en_i` is low, which puts all 18 pads in high impedance. It is 1 while `out_en_i` is high.
- R10: A START or STOP in the middle of a byte drops that byte and leaves every register unchanged.
- R11: Bytes after the sixth in a transaction are acknowledged and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial bus clock line |
| sda_i | input | 1 | Serial bus data line, as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the open-drain data line low (acknowledge) |
| ref_clk_i | input | 1 | Reference clock to be fanned out |
| out_en_i | input | 1 | Global pad enable; low floats all outputs |
| clk_o | output | 18 | Gated clock copies |
| pad_drive_o | output | 1 | 1 while the output pads are driving |

## Verification
The checks assume that the bus lines stay steady for longer than the synchronizer plus the three-sample filter, so that no START or STOP is mistaken for a data edge. They also assume that the master changes the data line only while the bus clock is low, except when it sends START or STOP. The stimulus uses a quarter bus period of ten system clocks, well above the six-cycle filter latency. The master releases the data line before every acknowledge slot and moves it only in the middle of the low phase.

// File: rtl/i2cen_pkg.sv
`timescale 1ns/1ps
package i2cen_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_DATA,
        ST_IGNORE
    } bus_state_e;

    localparam int BYTE_W    = 8;
    localparam int HDR_BYTES = 2;   // command + count bytes, both discarded
endpackage

// File: rtl/i2cen_line_filter.sv
`timescale 1ns/1ps
module i2cen_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q)
                line_o <= 1'b1;
            else if (~|hist_q)
                line_o <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cen_bus_fsm.sv
`timescale 1ns/1ps
module i2cen_bus_fsm
    import i2cen_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101001,
    parameter int         N_DATA   = 3,
    localparam int        SEL_W    = $clog2(N_DATA),
    localparam int        IDX_W    = $clog2(HDR_BYTES + N_DATA + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [SEL_W-1:0]  wr_sel_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    bus_state_e        state_q, state_d;
    logic              scl_q, sda_q;
    logic [3:0]        bitcnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;

    logic scl_rise, scl_fall, start_c, stop_c, byte_done, addr_ok, idx_is_data;

    assign scl_rise    = scl_f & ~scl_q;
    assign scl_fall    = ~scl_f & scl_q;
    assign start_c     = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_c      = scl_f & scl_q & ~sda_q & sda_f;
    assign byte_done   = (bitcnt_q == 4'd8);
    assign addr_ok     = (shreg_q == {DEV_ADDR, 1'b0});
    assign idx_is_data = (int'(idx_q) >= HDR_BYTES) && (int'(idx_q) < HDR_BYTES + N_DATA);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_c)
            state_d = ST_ADDR;
        else if (stop_c)
            state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_IGNORE: state_d = ST_IGNORE;
                ST_ADDR:   if (scl_fall && byte_done)
                               state_d = addr_ok ? ST_ACK : ST_IGNORE;
                ST_DATA:   if (scl_fall && byte_done)
                               state_d = ST_ACK;
                ST_ACK:    if (scl_fall)
                               state_d = ST_DATA;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // bit and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            bitcnt_q  <= '0;
            shreg_q   <= '0;
            idx_q     <= '0;
            wr_en_o   <= 1'b0;
            wr_sel_o  <= '0;
            wr_data_o <= '0;
        end else begin
            scl_q   <= scl_f;
            sda_q   <= sda_f;
            wr_en_o <= 1'b0;
            if (start_c || stop_c) begin
                bitcnt_q <= '0;
                idx_q    <= '0;
            end else begin
                if ((state_q == ST_ADDR || state_q == ST_DATA) && scl_rise && !byte_done) begin
                    shreg_q  <= {shreg_q[BYTE_W-2:0], sda_f};
                    bitcnt_q <= bitcnt_q + 4'd1;
                end
                if (state_q == ST_ACK && scl_fall)
                    bitcnt_q <= '0;
                if (state_q == ST_DATA && scl_fall && byte_done) begin
                    if (idx_is_data) begin
                        wr_en_o   <= 1'b1;
                        wr_sel_o  <= SEL_W'(int'(idx_q) - HDR_BYTES);
                        wr_data_o <= shreg_q;
                    end
                    if (idx_q != '1)
                        idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe_o = (state_q == ST_ACK);
    end
endmodule

// File: rtl/i2cen_enable_bank.sv
`timescale 1ns/1ps
module i2cen_enable_bank
    import i2cen_pkg::*;
#(
    parameter int  N_DATA = 3,
    localparam int SEL_W  = $clog2(N_DATA),
    localparam int OUT_W  = BYTE_W * (N_DATA - 1) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              ref_clk_i,
    output logic [OUT_W-1:0]  en_vec_o,
    output logic [OUT_W-1:0]  clk_o
);
    for (genvar i = 0; i < N_DATA - 1; i++) begin : g_full
        logic [BYTE_W-1:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q <= '1;
            else if (wr_en_i && wr_sel_i == SEL_W'(i))
                byte_q <= wr_data_i;
        end
        assign en_vec_o[i*BYTE_W +: BYTE_W] = byte_q;
    end

    // last register: only its top two bits gate outputs
    logic [1:0] tail_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tail_q <= '1;
        else if (wr_en_i && wr_sel_i == SEL_W'(N_DATA - 1))
            tail_q <= wr_data_i[BYTE_W-1 -: 2];
    end
    assign en_vec_o[OUT_W-1 -: 2] = tail_q;

    assign clk_o = en_vec_o & {OUT_W{ref_clk_i}};
endmodule

// File: rtl/i2cen_top.sv
`timescale 1ns/1ps
module i2cen_top
    import i2cen_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1101001,
    parameter int         N_DATA      = 3,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    localparam int        SEL_W       = $clog2(N_DATA),
    localparam int        OUT_W       = BYTE_W * (N_DATA - 1) + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic             ref_clk_i,
    input  logic             out_en_i,
    output logic [OUT_W-1:0] clk_o,
    output logic             pad_drive_o
);
    logic [1:0]        raw_lines, filt_lines;
    logic              scl_f, sda_f;
    logic              wr_en;
    logic [SEL_W-1:0]  wr_sel;
    logic [BYTE_W-1:0] wr_data;
    logic [OUT_W-1:0]  en_vec;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2cen_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    i2cen_bus_fsm #(
        .DEV_ADDR(DEV_ADDR),
        .N_DATA  (N_DATA)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .sda_oe_o (sda_oe_o),
        .wr_en_o  (wr_en),
        .wr_sel_o (wr_sel),
        .wr_data_o(wr_data)
    );

    i2cen_enable_bank #(
        .N_DATA(N_DATA)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_sel_i (wr_sel),
        .wr_data_i(wr_data),
        .ref_clk_i(ref_clk_i),
        .en_vec_o (en_vec),
        .clk_o    (clk_o)
    );

    assign pad_drive_o = out_en_i;
endmodule

// File: rtl/i2cen_chk.sv
`timescale 1ns/1ps
module i2cen_chk #(
    parameter int N_DATA = 3,
    parameter int SEL_W  = 2,
    parameter int OUT_W  = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_f,
    input logic             sda_oe,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [OUT_W-1:0] en_vec,
    input logic [OUT_W-1:0] clk_o
);
    AST_ACK_IN_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);                               // R2

    AST_WRITE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe);                                       // R4

    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_sel) < N_DATA));                      // R4

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_vec));                             // R10

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_o & ~en_vec) == '0);                                // R8
endmodule

bind i2cen_top i2cen_chk #(
    .N_DATA(N_DATA),
    .SEL_W (SEL_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_f (scl_f),
    .sda_oe(sda_oe_o),
    .wr_en (wr_en),
    .wr_sel(wr_sel),
    .en_vec(en_vec),
    .clk_o (clk_o)
);

// File: tb/i2cen_top_tb.sv
`timescale 1ns/1ps
module i2cen_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;   // quarter bus period in system clocks

    typedef struct {
        logic [17:0] val;
        logic        pad;
        string       req;
    } exp_t;

    logic        clk = 0, rst_n = 0;
    logic        scl_m = 1, sda_m = 1;
    logic        ref_clk = 0, out_en = 1;
    logic        sda_oe, pad_drive;
    logic [17:0] clk_o;
    wire         sda_line = sda_m & ~sda_oe;

    int checks = 0, failures = 0;
    bit done = 0;
    exp_t sb_q[$];
    logic [7:0] m_r0 = 8'hFF, m_r1 = 8'hFF, m_r2 = 8'hFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cen_top u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .ref_clk_i(ref_clk), .out_en_i(out_en),
        .clk_o(clk_o), .pad_drive_o(pad_drive)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic qwait(input int n);
        repeat (n * Q) @(posedge clk);
    endtask

    function automatic logic [17:0] model_vec();
        return {m_r2[7:6], m_r1, m_r0};
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            exp_t it;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            chk(clk_o === it.val, it.req, 32'(clk_o), 32'(it.val));
            chk(pad_drive === it.pad, it.req, 32'(pad_drive), 32'(it.pad));
        end
    end

    // driver: push expectations for ref high and ref low
    task automatic expect_out(input string req);
        exp_t it;
        @(negedge clk); ref_clk = 1; #1;
        it.val = model_vec(); it.pad = out_en; it.req = req;
        sb_q.push_back(it);
        @(negedge clk); ref_clk = 0; #1;
        it.val = '0; it.req = {req, "/R8"};
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; qwait(1); scl_m = 1; qwait(1);
        sda_m = 0; qwait(1); scl_m = 0; qwait(1);
    endtask

    task automatic bus_stop();
        sda_m = 0; qwait(1); scl_m = 1; qwait(1); sda_m = 1; qwait(2);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; qwait(1); scl_m = 1; qwait(2); scl_m = 0; qwait(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1; qwait(1); scl_m = 1; qwait(1);
        ack = (sda_line == 1'b0);
        qwait(1); scl_m = 0; qwait(1);
    endtask

    task automatic txn(input logic [7:0] addr, input logic [7:0] pl [8], input int n,
                       input bit exp_ack, input string req);
        bit ack;
        bus_start();
        send_byte(addr, ack);
        chk(ack == exp_ack, req, 32'(ack), 32'(exp_ack));
        for (int k = 0; k < n; k++) begin
            send_byte(pl[k], ack);
            chk(ack == exp_ack, req, 32'(ack), 32'(exp_ack));
        end
        bus_stop();
        if (exp_ack) begin
            if (n > 2) m_r0 = pl[2];
            if (n > 3) m_r1 = pl[3];
            if (n > 4) m_r2 = pl[4];
        end
    endtask

    initial begin
        bit ack;
        repeat (5) @(posedge clk);
        rst_n = 1;
        repeat (5) @(posedge clk);

        // R1: reset state, all enabled
        expect_out("R1");

        // R2 R4 R7: full write, MSB-first bytes
        txn(8'hD2, '{8'h55, 8'hAA, 8'hA5, 8'h3C, 8'h40, 0, 0, 0}, 5, 1, "R2");
        expect_out("R4");

        // R7: reserved bits of reg 2 have no effect
        txn(8'hD2, '{8'h00, 8'h00, 8'hA5, 8'h3C, 8'hBF, 0, 0, 0}, 5, 1, "R7");
        expect_out("R7");
        txn(8'hD2, '{8'h00, 8'h00, 8'hA5, 8'h3C, 8'h80, 0, 0, 0}, 5, 1, "R7");
        expect_out("R7");

        // R5: short transactions
        txn(8'hD2, '{8'h00, 8'h00, 8'h0F, 0, 0, 0, 0, 0}, 3, 1, "R5");
        expect_out("R5");
        txn(8'hD2, '{8'h00, 8'h00, 8'h11, 8'h22, 0, 0, 0, 0}, 4, 1, "R5");
        expect_out("R5");

        // R6: each transaction restarts at the command byte
        txn(8'hD2, '{8'h7E, 8'h03, 8'hF0, 0, 0, 0, 0, 0}, 3, 1, "R6");
        expect_out("R6");

        // R3: wrong address, then read request
        txn(8'hD4, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0}, 5, 0, "R3");
        expect_out("R3");
        txn(8'hD3, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0}, 5, 0, "R3");
        expect_out("R3");

        // R10: STOP in the middle of data byte 0
        bus_start();
        send_byte(8'hD2, ack); chk(ack, "R10", 32'(ack), 1);
        send_byte(8'h00, ack); send_byte(8'h00, ack);
        send_bits(8'h00, 4);
        bus_stop();
        expect_out("R10");

        // R10: START in the middle of data byte 0, then a fresh short write
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, ack); send_byte(8'h00, ack);
        send_bits(8'h00, 5);
        txn(8'hD2, '{8'h00, 8'h00, 8'hC3, 0, 0, 0, 0, 0}, 3, 1, "R10");
        expect_out("R10");

        // R11: bytes beyond the sixth are acked and dropped
        txn(8'hD2, '{8'h00, 8'h00, 8'h96, 8'h69, 8'hC0, 8'h00, 8'h00, 8'h00}, 8, 1, "R11");
        expect_out("R11");

        // R8: all disabled -> outputs low even with ref high
        txn(8'hD2, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0}, 5, 1, "R8");
        expect_out("R8");

        // R9: global pad enable
        out_en = 0;
        expect_out("R9");
        out_en = 1;
        expect_out("R9");

        wait (sb_q.size() == 0);
        #1;
        done = 1;
    end

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                failures++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
            wait (done);
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule